// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the next microaddress of a microprogrammed controller with 8-bit microaddresses. The control store is external. It is addressed by the current microaddress, and it returns a base next address and a 5-bit branch selector. The selector picks which condition inputs are driven onto the low branch lines. Those lines are ORed into the base address. A base address whose low bits are zero therefore becomes a two-way or eight-way branch.

For diagnosis the block keeps both the current and the previous microaddress. It can run freely, advance one microword per manual step request, or park on an address. Parking uses a comparator: when the current microaddress equals a set of switch bits, a match is flagged, and with stop-on-match enabled the sequencer holds there. Stop-on-match applies in both free-run and single-step modes.

Top module: `useq_next`

## Requirements
- R1: While `rst` is high at a clock edge, both `cur_addr_o` and `prev_addr_o` are loaded with `RESET_ADDR` (default 0x00).
- R2: With a branch selector other than 6 or 24, an advance loads `cur_addr_o` with exactly `base_next_i`.
- R3: Selector value 6 ORs `cond_i[0]` (switch pending) into bit 0 of the base address.
- R4: Selector value 24 (octal 30) ORs the console command `cond_i[3:1]` into bits 2..0 of the base address, with `cond_i[1]` going to bit 0.
- R5: The merge is a pure OR: a base bit that is already 1 stays 1 whatever the conditions are.
- R6: On every advance, `prev_addr_o` takes the value that `cur_addr_o` held before the advance.
- R7: `match_o` is high exactly when `cur_addr_o` equals `sw_i`.
- R8: While `stop_en_i` and `match_o` are both high, the sequencer does not advance. Clearing `stop_en_i` lets it advance at the next edge.
- R9: With `step_mode_i` high, the sequencer holds unless a step is requested. Each rising edge of `step_req_i`, however long the request is held, produces exactly one advance. The advance comes at the third clock edge after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_next_i | input | 8 | Base next address from the current microword |
| bsel_i | input | 5 | Branch selector from the current microword |
| cond_i | input | 4 | Conditions: bit 0 switch pending, bits 3..1 console command |
| step_mode_i | input | 1 | Single-step mode enable |
| step_req_i | input | 1 | Manual step request, asynchronous |
| stop_en_i | input | 1 | Stop-on-address-match enable |
| sw_i | input | 8 | Switch bits compared with the current address |
| cur_addr_o | output | 8 | Current microaddress |
| prev_addr_o | output | 8 | Previous microaddress |
| match_o | output | 1 | Current address equals switch bits |

## Verification
The assertions check several rules on every cycle: an address that is parked or waiting for a step stays held, the previous address follows each advance, a free-run advance keeps every base bit set, a plain selector yields exactly the base, and a step pulse never lasts two cycles. Only the bench scenarios can show that the right condition bits reach the right address bits for each selector value. The bench also confirms the full park, step and resume flow against a control-store model and that one long press gives one step.

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW = 8,
  parameter int BFW = 5,
  parameter int CW = 4,
  parameter int RESET_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_next_i,
  input  logic [BFW-1:0] bsel_i,
  input  logic [CW-1:0] cond_i,
  input  logic          step_mode_i,
  input  logic          step_req_i,
  input  logic          stop_en_i,
  input  logic [AW-1:0] sw_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] prev_addr_o,
  output logic          match_o
);
  localparam logic [BFW-1:0] SEL_PEND = BFW'(6);
  localparam logic [BFW-1:0] SEL_CMD  = BFW'(24);
  localparam logic [AW-1:0]  ADDR_RST = AW'(RESET_ADDR);

  logic [AW-1:0] branch;
  logic [2:0]    req_sync;
  logic          step_pulse;
  logic          adv;

  always_comb begin
    branch = '0;
    case (bsel_i)
      SEL_PEND: branch[0]   = cond_i[0];
      SEL_CMD:  branch[2:0] = cond_i[3:1];
      default:  branch      = '0;
    endcase
  end

  assign match_o    = (cur_addr_o == sw_i);
  assign step_pulse = req_sync[1] & ~req_sync[2];
  assign adv        = (step_mode_i ? step_pulse : 1'b1) & ~(stop_en_i & match_o);

  always_ff @(posedge clk) begin
    if (rst) req_sync <= '0;
    else     req_sync <= {req_sync[1:0], step_req_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr_o  <= ADDR_RST;
      prev_addr_o <= ADDR_RST;
    end else if (adv) begin
      prev_addr_o <= cur_addr_o;
      cur_addr_o  <= base_next_i | branch;
    end
  end
endmodule

module useq_next_chk #(
  parameter int AW = 8,
  parameter int BFW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] base_next_i,
  input logic [BFW-1:0] bsel_i,
  input logic          step_mode_i,
  input logic          stop_en_i,
  input logic          step_pulse,
  input logic [AW-1:0] cur_addr_o,
  input logic [AW-1:0] prev_addr_o,
  input logic          match_o
);
  assert_park_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_en_i && match_o) |=> (cur_addr_o == $past(cur_addr_o)));

  assert_step_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (step_mode_i && !step_pulse) |=> (cur_addr_o == $past(cur_addr_o)));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);

  assert_prev_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (step_pulse || !step_mode_i) && !(stop_en_i && match_o) |=> (prev_addr_o == $past(cur_addr_o)));

  assert_or_keeps_base_R5: assert property (@(posedge clk) disable iff (rst)
    (!step_mode_i && !(stop_en_i && match_o)) |=> ((cur_addr_o & $past(base_next_i)) == $past(base_next_i)));

  assert_plain_base_R2: assert property (@(posedge clk) disable iff (rst)
    (!step_mode_i && !(stop_en_i && match_o) && bsel_i != BFW'(6) && bsel_i != BFW'(24))
      |=> (cur_addr_o == $past(base_next_i)));
endmodule

bind useq_next useq_next_chk #(.AW(AW), .BFW(BFW)) u_chk (
  .clk(clk), .rst(rst), .base_next_i(base_next_i), .bsel_i(bsel_i),
  .step_mode_i(step_mode_i), .stop_en_i(stop_en_i), .step_pulse(step_pulse),
  .cur_addr_o(cur_addr_o), .prev_addr_o(prev_addr_o), .match_o(match_o));

// File: tb/test_useq_next.sv
module test_useq_next;
  logic       clk = 0, rst = 1;
  logic [7:0] base, sw = 8'h00;
  logic [4:0] bsel;
  logic [3:0] cond = 4'h0;
  logic       step_mode = 0, step_req = 0, stop_en = 0;
  logic [7:0] cur, prev;
  logic       match;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  useq_next i_useq_next (
    .clk(clk), .rst(rst), .base_next_i(base), .bsel_i(bsel), .cond_i(cond),
    .step_mode_i(step_mode), .step_req_i(step_req), .stop_en_i(stop_en),
    .sw_i(sw), .cur_addr_o(cur), .prev_addr_o(prev), .match_o(match));

  // control store model
  always_comb begin
    base = cur + 8'h01;
    bsel = 5'd0;
    case (cur)
      8'h10: begin base = 8'h40; bsel = 5'd6;  end
      8'h40: begin base = 8'h50; bsel = 5'd24; end
      8'h41: begin base = 8'h47; bsel = 5'd24; end
      default: ;
    endcase
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; step_mode = 0; stop_en = 0; step_req = 0; cond = 0;
    wait_cyc(3);
  endtask

  task automatic park(input logic [7:0] a);
    do_reset();
    sw = a; stop_en = 1;
    rst = 0;
    wait_cyc(40);
  endtask

  task automatic step_once();
    step_req = 1;
    wait_cyc(6);
    step_req = 0;
    wait_cyc(6);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cur", cur, 8'h00);
    chk("R1 prev", prev, 8'h00);
  endtask

  task automatic t_freerun();
    do_reset();
    sw = 8'hFF;
    rst = 0;
    @(negedge clk);
    chk("R2 first", cur, 8'h01);
    chk("R6 first prev", prev, 8'h00);
    wait_cyc(3);
    chk("R2 count", cur, 8'h04);
    chk("R6 count prev", prev, 8'h03);
    chk("R7 no match", {7'd0, match}, 8'h00);
  endtask

  task automatic t_park_resume();
    park(8'h05);
    chk("R8 parked", cur, 8'h05);
    chk("R7 match", {7'd0, match}, 8'h01);
    stop_en = 0;
    @(negedge clk);
    chk("R8 resume", cur, 8'h06);
    chk("R6 resume prev", prev, 8'h05);
  endtask

  task automatic t_pend_and_or();
    park(8'h10);
    chk("R8 park 10", cur, 8'h10);
    step_mode = 1; stop_en = 0; cond = 4'b0001;
    wait_cyc(20);
    chk("R9 hold no request", cur, 8'h10);
    step_once();
    chk("R3 pending set", cur, 8'h41);
    chk("R6 prev step", prev, 8'h10);
    cond = 4'b0000;
    step_once();
    chk("R5 or keeps base", cur, 8'h47);
    chk("R9 one step", prev, 8'h41);
  endtask

  task automatic t_cmd();
    park(8'h10);
    step_mode = 1; stop_en = 0; cond = 4'b0000;
    step_once();
    chk("R3 pending clear", cur, 8'h40);
    cond = 4'b1010;
    step_once();
    chk("R4 command 101", cur, 8'h55);
  endtask

  task automatic t_step_timing();
    park(8'h08);
    step_mode = 1; stop_en = 0;
    step_req = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 not yet", cur, 8'h08);
    @(negedge clk);
    chk("R9 third edge", cur, 8'h09);
    wait_cyc(10);
    chk("R9 long press one step", cur, 8'h09);
    step_req = 0;
    wait_cyc(4);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_freerun();
        t_park_resume();
        t_pend_and_or();
        t_cmd();
        t_step_timing();
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule